// File: doc/BRIEF.md
# Memory map overlay decoder

This block decodes the 16-bit address bus of an 8-bit processor system into four chip selects: main RAM, boot ROM and two peripheral register windows, called A and B. The lowest 63 KB always go to RAM. The top 1 KB is divided among the two peripheral windows, the ROM and the interrupt vector bytes. An 8-bit overlay control register at FFF9 lets software swap any of these upper regions for the RAM that lies underneath. The register itself can never be swapped out.

The overlay only affects accesses made by the CPU. Other bus masters, such as video fetch, refresh or a sprite engine, always see a flat 64 KB of RAM. The selects are combinational from the address, the strobes and the master flag. The control register is updated on the clock edge that ends a CPU write to FFF9, so a new overlay setting governs decoding from the following cycle.

Top module: `memmap_overlay_dec`

## Requirements
- R1: For any access (read or write strobe high) below FC00, only `ram_cs` is active, whatever the master and the overlay bits.
- R2: For an access with `cpu_master`=0, only `ram_cs` is active at every address, FFF8 and FFF9 included.
- R3: With all overlay bits clear, a CPU access decodes as follows: FC00–FCFF selects peripheral B, FD00–FDFF selects peripheral A, and FE00–FFF7 and FFFA–FFFF select ROM.
- R4: Overlay bit 0 turns FC00–FCFF into RAM. Bit 1 does the same for FD00–FDFF, bit 2 for FE00–FFF7 and bit 3 for FFFA–FFFF. A 1 selects RAM. Each bit affects only its own region.
- R5: A CPU access to FFF8 always selects ROM, whatever the overlay bits.
- R6: A CPU write to FFF9 activates both `pera_cs` and `perb_cs` and neither RAM nor ROM. The register takes `wdata` at that clock edge, and the new value governs decoding from the next cycle.
- R7: A CPU read of FFF9 activates only `pera_cs` and drives all 8 stored bits on `ctl_rdata`. Bit 7 (the high-speed flag) and bits 6..4 read back as written and have no decode effect.
- R8: Reset clears all 8 register bits, so decoding returns to the R3 map.
- R9: With no strobe, no chip select is active. For every access except the CPU write of R6, exactly one chip select is active.
- R10: `ctl_rdata` is 0 except during a CPU read of FFF9.
- R11: A write to FFF9 by a non-CPU master leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the overlay register |
| addr | input | 16 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| cpu_master | input | 1 | 1 when the CPU owns the bus, 0 for any other master |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 1 | ROM select |
| pera_cs | output | 1 | Peripheral A window select |
| perb_cs | output | 1 | Peripheral B window select |
| ctl_rdata | output | 8 | Overlay register read data |

## Verification
Some properties are checked by assertions on every cycle:
- the select-count rule;
- flat RAM for non-CPU masters and for low addresses;
- FFF8 always selecting ROM;
- the dual select on a register write;
- the quiet read data bus;
- write-then-read coherence of the register.

Other behaviour can only be shown by the bench's scenarios. Which region each overlay bit swaps depends on the register contents, so the bench walks all 16 values of bits 3..0 over probe addresses at each region edge, for both kinds of master. Reset clearing, inert upper bits and a non-CPU write being ignored are shown through register read-back.

// File: rtl/memmap_overlay_pkg.sv
package memmap_overlay_pkg;

  // Decoded address regions
  typedef enum logic [2:0] {
    RG_LOW   = 3'd0,  // flat RAM below the shared window
    RG_PERB  = 3'd1,
    RG_PERA  = 3'd2,
    RG_ROM   = 3'd3,
    RG_FIXED = 3'd4,  // byte that always stays ROM
    RG_CTL   = 3'd5,  // overlay control register
    RG_VEC   = 3'd6
  } region_e;

  // Number of regions that can be overlaid, one register bit each
  localparam int OVL_W = 4;

  // Register bit i overlays OVL_REGION[i]
  localparam region_e OVL_REGION [OVL_W] = '{RG_PERB, RG_PERA, RG_ROM, RG_VEC};

  // Byte offsets inside the top page
  localparam logic [7:0] FIXED_OFS = 8'hF8;
  localparam logic [7:0] CTL_OFS   = FIXED_OFS + 8'd1;

  // Select vector packing {ram, rom, pera, perb}
  function automatic logic [3:0] pack_cs(input logic ram, input logic rom,
                                         input logic pa, input logic pb);
    return {ram, rom, pa, pb};
  endfunction

endpackage

// File: rtl/mo_region_classify.sv
module mo_region_classify
  import memmap_overlay_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int WIN_LSB = 10;  // top 1 KB window
  localparam int PAGE_LSB = 8;  // 256-byte pages inside it

  logic in_window;
  logic [1:0] page;
  logic [7:0] ofs;

  assign in_window = &addr[ADDR_W-1:WIN_LSB];
  assign page      = addr[WIN_LSB-1:PAGE_LSB];
  assign ofs       = addr[PAGE_LSB-1:0];

  always_comb begin
    region = RG_LOW;
    if (in_window) begin
      unique case (page)
        2'b00:   region = RG_PERB;
        2'b01:   region = RG_PERA;
        2'b10:   region = RG_ROM;
        default: begin
          if (ofs == FIXED_OFS)    region = RG_FIXED;
          else if (ofs == CTL_OFS) region = RG_CTL;
          else if (ofs > CTL_OFS)  region = RG_VEC;
          else                     region = RG_ROM;
        end
      endcase
    end
  end
endmodule

// File: rtl/mo_ctl_reg.sv
module mo_ctl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_evt) ctl_q <= wdata;
  end
endmodule

// File: rtl/mo_select.sv
module mo_select
  import memmap_overlay_pkg::*;
(
  input  region_e          region,
  input  logic             access,
  input  logic             cpu_master,
  input  logic             wr_en,
  input  logic [OVL_W-1:0] ovl_mask,
  output logic [3:0]       cs_vec
);
  logic [OVL_W-1:0] ovl_hit;

  for (genvar i = 0; i < OVL_W; i++) begin : g_ovl
    assign ovl_hit[i] = (region == OVL_REGION[i]) && ovl_mask[i];
  end

  always_comb begin
    cs_vec = 4'b0000;
    if (access) begin
      if (!cpu_master || (|ovl_hit)) begin
        cs_vec = pack_cs(1'b1, 1'b0, 1'b0, 1'b0);
      end else begin
        unique case (region)
          RG_LOW:   cs_vec = pack_cs(1'b1, 1'b0, 1'b0, 1'b0);
          RG_PERB:  cs_vec = pack_cs(1'b0, 1'b0, 1'b0, 1'b1);
          RG_PERA:  cs_vec = pack_cs(1'b0, 1'b0, 1'b1, 1'b0);
          RG_CTL:   cs_vec = pack_cs(1'b0, 1'b0, 1'b1, wr_en);
          default:  cs_vec = pack_cs(1'b0, 1'b1, 1'b0, 1'b0);
        endcase
      end
    end
  end
endmodule

// File: rtl/memmap_overlay_dec.sv
module memmap_overlay_dec
  import memmap_overlay_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cpu_master,
  output logic              ram_cs,
  output logic              rom_cs,
  output logic              pera_cs,
  output logic              perb_cs,
  output logic [DATA_W-1:0] ctl_rdata
);
  region_e           region;
  logic              access;
  logic              ctl_hit;
  logic              ctl_wr_evt;  // named event for the checker
  logic              ctl_rd_evt;
  logic [DATA_W-1:0] ctl_q;
  logic [3:0]        cs_vec;

  mo_region_classify #(.ADDR_W(ADDR_W)) u_class (
    .addr   (addr),
    .region (region)
  );

  assign access     = rd_en || wr_en;
  assign ctl_hit    = cpu_master && (region == RG_CTL);
  assign ctl_wr_evt = ctl_hit && wr_en;
  assign ctl_rd_evt = ctl_hit && rd_en;

  mo_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_evt (ctl_wr_evt),
    .wdata  (wdata),
    .ctl_q  (ctl_q)
  );

  mo_select u_sel (
    .region     (region),
    .access     (access),
    .cpu_master (cpu_master),
    .wr_en      (wr_en),
    .ovl_mask   (ctl_q[OVL_W-1:0]),
    .cs_vec     (cs_vec)
  );

  assign {ram_cs, rom_cs, pera_cs, perb_cs} = cs_vec;
  assign ctl_rdata = ctl_rd_evt ? ctl_q : '0;
endmodule

// File: rtl/memmap_overlay_chk.sv
module memmap_overlay_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              cpu_master,
  input logic              ram_cs,
  input logic              rom_cs,
  input logic              pera_cs,
  input logic              perb_cs,
  input logic [DATA_W-1:0] ctl_rdata,
  input logic              ctl_wr_evt
);
  localparam logic [ADDR_W-1:0] TOP      = '1;
  localparam logic [ADDR_W-1:0] CTL_ADDR = TOP - ADDR_W'(6);
  localparam logic [ADDR_W-1:0] FIX_ADDR = TOP - ADDR_W'(7);
  localparam logic [ADDR_W-1:0] WIN_BASE = TOP - ADDR_W'(1023);

  logic acc;
  logic cpu_ctl_wr;
  logic cpu_ctl_rd_only;
  logic past_ok;

  assign acc             = rd_en || wr_en;
  assign cpu_ctl_wr      = cpu_master && wr_en && (addr == CTL_ADDR);
  assign cpu_ctl_rd_only = cpu_master && rd_en && !wr_en && (addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> ({ram_cs, rom_cs, pera_cs, perb_cs} == 4'b0000));

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cpu_ctl_wr) |-> $onehot({ram_cs, rom_cs, pera_cs, perb_cs}));

  // R1
  low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && addr < WIN_BASE) |-> ram_cs);

  // R2
  other_master_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cpu_master) |-> ram_cs);

  // R5
  fixed_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cpu_master && addr == FIX_ADDR) |-> rom_cs);

  // R6
  ctl_write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ctl_wr |-> (pera_cs && perb_cs && !ram_cs && !rom_cs && ctl_wr_evt));

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_master && rd_en && addr == CTL_ADDR) |-> (ctl_rdata == '0));

  // R6
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cpu_ctl_rd_only && $past(ctl_wr_evt)) |-> (ctl_rdata == $past(wdata)));
endmodule

bind memmap_overlay_dec memmap_overlay_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .cpu_master (cpu_master),
  .ram_cs     (ram_cs),
  .rom_cs     (rom_cs),
  .pera_cs    (pera_cs),
  .perb_cs    (perb_cs),
  .ctl_rdata  (ctl_rdata),
  .ctl_wr_evt (ctl_wr_evt)
);

// File: tb/sim_memmap_overlay_dec.sv
`timescale 1ns/1ps
module sim_memmap_overlay_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        cpu_master = 1'b0;
  logic        ram_cs, rom_cs, pera_cs, perb_cs;
  logic [7:0]  ctl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  memmap_overlay_dec u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .cpu_master(cpu_master), .ram_cs(ram_cs), .rom_cs(rom_cs),
    .pera_cs(pera_cs), .perb_cs(perb_cs), .ctl_rdata(ctl_rdata)
  );

  // Probe table: address and kind
  // kind 0 low RAM, 1 periph B, 2 periph A, 3 ROM, 4 fixed ROM byte, 5 vector
  localparam int NPROBE = 12;
  localparam logic [15:0] PROBE_A [NPROBE] = '{
    16'h0000, 16'h8123, 16'hFBFF, 16'hFC00, 16'hFCFF, 16'hFD00,
    16'hFDFF, 16'hFE00, 16'hFFF7, 16'hFFF8, 16'hFFFA, 16'hFFFF};
  localparam logic [2:0] PROBE_K [NPROBE] = '{
    3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd5, 3'd5};

  // Expected {ram, rom, pera, perb}
  function automatic logic [3:0] want_cs(input logic [2:0] kind,
                                         input logic [3:0] mask, input logic cpu);
    if (!cpu) return 4'b1000;
    case (kind)
      3'd1:    return mask[0] ? 4'b1000 : 4'b0001;
      3'd2:    return mask[1] ? 4'b1000 : 4'b0010;
      3'd3:    return mask[2] ? 4'b1000 : 4'b0100;
      3'd4:    return 4'b0100;
      3'd5:    return mask[3] ? 4'b1000 : 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h cpu=%b)", req, act, exp, addr, cpu_master);
    end
  endtask

  // Drive at the falling edge, settle, leave the caller to sample
  task automatic drive(input logic [15:0] a, input logic r, input logic w,
                       input logic cpu, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; cpu_master = cpu; wdata = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    #2;
  endtask

  function automatic logic [7:0] cs_now();
    return {4'b0, ram_cs, rom_cs, pera_cs, perb_cs};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: register clear after reset, R7: read select
    drive(16'hFFF9, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R8", ctl_rdata, 8'h00);
    chk("R7", cs_now(), 8'h02);

    // R9: no strobe, no select
    drive(16'hFC10, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R9", cs_now(), 8'h00);

    // Table walk: R1 R2 R3 R4 R5 for every mask and both masters
    for (int m = 0; m < 16; m++) begin
      logic [7:0] val;
      val = {m[0], 3'b101 ^ m[3:1], m[3:0]};
      drive(16'hFFF9, 1'b0, 1'b1, 1'b1, val);
      chk("R6", cs_now(), 8'h03);
      drive(16'hFFF9, 1'b1, 1'b0, 1'b1, 8'h00);
      chk("R7", ctl_rdata, val);
      for (int p = 0; p < NPROBE; p++) begin
        for (int c = 0; c < 2; c++) begin
          drive(PROBE_A[p], (c == 0), (c == 1), c[0] ^ p[0], 8'h5A);
          chk(PROBE_K[p] == 0 ? "R1" : (!(c[0] ^ p[0]) ? "R2" :
              (PROBE_K[p] == 4 ? "R5" : (m == 0 ? "R3" : "R4"))),
              cs_now(), {4'b0, want_cs(PROBE_K[p], m[3:0], c[0] ^ p[0])});
          // R10: no register data outside its own read
          chk("R10", ctl_rdata, 8'h00);
        end
      end
      // Same probes, the other master
      for (int p = 0; p < NPROBE; p++) begin
        drive(PROBE_A[p], 1'b1, 1'b0, ~p[0], 8'h00);
        chk(~p[0] ? "R4" : "R2", cs_now(), {4'b0, want_cs(PROBE_K[p], m[3:0], ~p[0])});
      end
    end

    // R7: high-speed flag and bits 6..4 stored, no decode effect
    drive(16'hFFF9, 1'b0, 1'b1, 1'b1, 8'hF0);
    idle();
    drive(16'hFFF9, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7", ctl_rdata, 8'hF0);
    drive(16'hFC40, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7", cs_now(), 8'h01);
    drive(16'hFFFC, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7", cs_now(), 8'h04);

    // R11: non-CPU write to FFF9 ignored, and it selects RAM (R2)
    drive(16'hFFF9, 1'b0, 1'b1, 1'b0, 8'h0F);
    chk("R2", cs_now(), 8'h08);
    idle();
    drive(16'hFFF9, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R11", ctl_rdata, 8'hF0);
    drive(16'hFD20, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R11", cs_now(), 8'h02);

    // R6: new value takes effect on the very next cycle
    drive(16'hFFF9, 1'b0, 1'b1, 1'b1, 8'h02);
    drive(16'hFD20, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R6", cs_now(), 8'h08);

    // R8: reset in mid-run restores the default map
    drive(16'hFFF9, 1'b0, 1'b1, 1'b1, 8'hFF);
    idle();
    rst_n = 1'b0;
    #3;
    drive(16'hFE80, 1'b1, 1'b0, 1'b1, 8'h00);
    rst_n = 1'b1;
    #1;
    chk("R8", cs_now(), 8'h04);
    drive(16'hFFF9, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R8", ctl_rdata, 8'h00);

    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule